// File: doc/BRIEF.md
# Pointer-Indirected Data Register File

This block is a small byte-wide data register file with one read/write port. Besides ordinary storage it holds a pointer register and a virtual location that has no storage of its own: any access made to the virtual location is redirected to the entry whose address the pointer currently holds. Software can walk through memory this way by loading the pointer once and then incrementing it, without coding a new direct address for each step.

The parameter `PTR_BITS` sets how many pointer bits exist: 5, 7 or 8. The five low bits give an offset from 00h to 1Fh inside a 32-byte bank. Any pointer bits above those select one of up to eight banks. Pointer bits that are not implemented always read back as 1.

The direct address input has the same layout as the pointer. In every bank, offset 00h is the virtual location and offset 04h is the pointer. All other offsets are storage. A read returns its value in the same cycle. A write is performed on the rising clock edge.

Top module: `ind_regfile`

## Requirements
- R1: After reset the implemented pointer bits are 0, so a read at offset 04h returns only the unimplemented-bit ones (80h with the default `PTR_BITS` = 7).
- R2: A write at offset 04h loads `wdata[PTR_BITS-1:0]` into the pointer at the clock edge. A read at offset 04h returns the pointer in the same cycle, with no extra latency.
- R3: Pointer bits 7 down to `PTR_BITS` always read as 1. Writing 00h to the pointer therefore reads back as 80h when `PTR_BITS` = 7, and writing 5Ah reads back as DAh.
- R4: A read at offset 00h returns the entry selected by the pointer. Pointer bits [4:0] give the offset and bits [PTR_BITS-1:5] give the bank.
- R5: A write at offset 00h stores `wdata` into the entry selected by the pointer. A direct read of that entry returns the new value from the next cycle on.
- R6: When the pointer offset bits [4:0] are 00000, in any bank, an access at offset 00h reads 00h. A write made that way changes no entry and does not change the pointer.
- R7: A direct access uses `addr[4:0]` as the offset and `addr[PTR_BITS-1:5]` as the bank. Every offset other than 00h and 04h is an independent byte of storage.
- R8: The same offset in different banks holds separate data. With `PTR_BITS` = 7, direct address 28h is a different entry from 08h, and the pointer can reach either one.
- R9: When the pointer offset bits [4:0] are 00100, an access at offset 00h reaches the pointer itself. The read returns the pointer value with the ones in its unimplemented bits, and a write reloads the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are performed on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the pointer |
| we | input | 1 | Write enable for the current address |
| addr | input | PTR_BITS | Direct address: bank in the upper bits, offset in bits [4:0] |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address, combinational |

## Verification
Every read result is due in the same cycle as the address that selects it. Every write, whether to storage or to the pointer, shows up in reads from the cycle after the edge that performs it. The bench drives each operation 2 ns after a rising edge. It records the expected byte in a queue, and a monitor checks it at the following falling edge. This way the read is always sampled in mid-cycle of the operation it belongs to, and the checks for any write come from a later operation that runs after the edge performing that write.

// File: rtl/ind_regfile.sv
module ind_regfile #(
  parameter int PTR_BITS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [PTR_BITS-1:0] addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata
);
  localparam int DEPTH = 1 << PTR_BITS;
  localparam logic [4:0] SELF_OFF = 5'h00;
  localparam logic [4:0] PTR_OFF  = 5'h04;
  localparam logic [7:0] HI_ONES  = 8'(8'hFF << PTR_BITS);

  logic [7:0]          mem [DEPTH];
  logic [PTR_BITS-1:0] ptr_q;
  logic [PTR_BITS-1:0] eff;
  logic                hit_self, hit_ptr;

  assign eff      = (addr[4:0] == SELF_OFF) ? ptr_q : addr;
  assign hit_self = (eff[4:0] == SELF_OFF);
  assign hit_ptr  = (eff[4:0] == PTR_OFF);

  assign rdata = hit_self ? 8'h00 :
                 hit_ptr  ? (HI_ONES | 8'(ptr_q)) :
                            mem[eff];

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (we && hit_ptr)
      ptr_q <= wdata[PTR_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (we && !hit_self && !hit_ptr)
      mem[eff] <= wdata;
  end
endmodule

// File: rtl/ind_regfile_chk.sv
module ind_regfile_chk #(
  parameter int PTR_BITS = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                we,
  input logic [PTR_BITS-1:0] addr,
  input logic [7:0]          wdata,
  input logic [7:0]          rdata,
  input logic [PTR_BITS-1:0] ptr_q
);
  localparam logic [7:0] HI = 8'(8'hFF << PTR_BITS);

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[4:0] == 5'h04) |=> ptr_q == $past(wdata[PTR_BITS-1:0]));

  // R3
  hi_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[4:0] == 5'h04) |-> ((rdata & HI) == HI));

  // R6
  self_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[4:0] == 5'h00 && ptr_q[4:0] == 5'h00) |-> rdata == 8'h00);

  // R6
  self_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[4:0] == 5'h00 && ptr_q[4:0] == 5'h00) |=> $stable(ptr_q));

  // R9
  ind_ptr_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[4:0] == 5'h00 && ptr_q[4:0] == 5'h04) |-> rdata == (HI | 8'(ptr_q)));
endmodule

bind ind_regfile ind_regfile_chk #(.PTR_BITS(PTR_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr),
  .wdata(wdata), .rdata(rdata), .ptr_q(ptr_q)
);

// File: tb/ind_regfile_bench.sv
module ind_regfile_bench;
  localparam int PB = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [PB-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          rd_pending = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  ind_regfile #(.PTR_BITS(PB)) u_ind_regfile (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always @(negedge clk) begin
    if (rd_pending && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s addr=%02h actual=%02h expected=%02h", t, addr, rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input logic [PB-1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    we = 1'b1; addr = a; wdata = d; rd_pending = 1'b0;
  endtask

  task automatic rd(input logic [PB-1:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #2;
    we = 1'b0; addr = a; rd_pending = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic idle();
    @(posedge clk); #2;
    we = 1'b0; rd_pending = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    rd(7'h04, 8'h80, "R1 reset pointer");
    wr(7'h04, 8'h5A);
    rd(7'h04, 8'hDA, "R2 pointer load");
    wr(7'h04, 8'h00);
    rd(7'h04, 8'h80, "R3 cleared pointer nonzero");
    wr(7'h08, 8'h10);
    wr(7'h09, 8'h0A);
    wr(7'h04, 8'h08);
    rd(7'h00, 8'h10, "R4 indirect read 08h");
    wr(7'h04, 8'h09);
    rd(7'h00, 8'h0A, "R4 indirect read after increment");
    wr(7'h04, 8'h00);
    rd(7'h00, 8'h00, "R6 self read");
    wr(7'h00, 8'h55);
    rd(7'h04, 8'h80, "R6 self write leaves pointer");
    rd(7'h08, 8'h10, "R6 self write leaves storage");
    wr(7'h28, 8'h77);
    rd(7'h08, 8'h10, "R8 bank 0 untouched");
    wr(7'h04, 8'h28);
    rd(7'h00, 8'h77, "R8 indirect bank 1");
    wr(7'h04, 8'h20);
    rd(7'h00, 8'h00, "R6 self read bank 1");
    wr(7'h04, 8'h0C);
    wr(7'h00, 8'h3C);
    rd(7'h0C, 8'h3C, "R5 indirect write");
    wr(7'h04, 8'h04);
    rd(7'h00, 8'h84, "R9 indirect reaches pointer");
    wr(7'h00, 8'h11);
    rd(7'h04, 8'h91, "R9 indirect pointer write");
    wr(7'h0F, 8'hF0);
    wr(7'h30, 8'hC3);
    for (int i = 0; i < 16; i++) wr(7'(8'h10 + i), 8'(8'hA0 + i));
    rd(7'h13, 8'hA3, "R7 direct storage");
    wr(7'h04, 8'h10);
    for (int i = 0; i < 16; i++) begin
      wr(7'h00, 8'h00);
      rd(7'h04, 8'(8'h90 + i), "R2 pointer walk");
      wr(7'h04, 8'(8'h11 + i));
    end
    for (int i = 0; i < 16; i++) rd(7'(8'h10 + i), 8'h00, "R5 cleared range");
    rd(7'h0F, 8'hF0, "R7 below range unchanged");
    rd(7'h30, 8'hC3, "R8 other bank unchanged");
    rd(7'h28, 8'h77, "R8 bank 1 kept");
    rd(7'h04, 8'hA0, "R3 pointer after walk");
    idle();
    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule